// File: doc/BRIEF.md
# Byte-Serial Slave Port with Collision Flag

This block is the receiving end of a four-wire synchronous serial link. An external master drives the serial clock, the select line and the master-to-slave data line. The block shifts one 8-bit frame, most significant bit first, into a receive register and at the same time shifts a host-loaded byte out on its slave-to-master data line. The idle level of the serial clock and the edge on which bits are sampled are chosen by two plain control inputs. They give four clock modes.

The host side is register-like, not a stream. A one-cycle write strobe loads the transmit byte. The last complete received byte is always readable on `rd_data`. Two sticky flags report a finished frame and a rejected write, and each has its own one-cycle clear pulse. The write strobe has no ready signal and never stalls: a write is either taken into the transmit register or dropped with the collision flag raised. The three serial inputs pass through two-flop synchronizers. The system clock must therefore run at least four times faster than the serial clock, and each serial clock level must last at least two system clocks.

When the clock phase bit is 0, the select line must be released and asserted again around every byte. When the clock phase bit is 1, the select line may stay low for several bytes in a row. The output enable for the slave-to-master line is high only while the slave is selected.

Top module: `spi_slave_port`

## Requirements
- R1: With `cpol`=0 the serial clock idles low, and with `cpol`=1 it idles high. The leading edge leaves the idle level. With `cpha`=0, bits are sampled on leading edges and launched on trailing edges. With `cpha`=1, bits are launched on leading edges and sampled on trailing edges.
- R2: A frame is 8 bits, most significant bit first, in both directions. The received byte appears on `rd_data` once the eighth bit has been sampled, and it stays there until the next frame completes.
- R3: With `cpha`=0, the most significant bit of the transmit register appears on `miso` once select is seen low, before any clock edge. The transmit register is copied into the shifter at that moment.
- R4: With `cpha`=1, several bytes may be sent under one continuous select. At the first leading edge of each byte, the transmit register is copied into the shifter.
- R5: `done_flag` goes to 1 after the eighth sample of a frame and stays at 1 until a `done_clr` pulse. If a completion and a clear fall in the same cycle, the completion wins.
- R6: A write while the port is busy is dropped and sets `wcol_flag`. The flag stays set until a `wcol_clr` pulse. The port is busy when select is low and either `cpha`=0, or `cpha`=1 and the current byte has started.
- R7: A write while the port is not busy loads `wr_data` into the transmit register. This includes a write between bytes under a continuous select with `cpha`=1.
- R8: `miso_oe` is 1 only while select is low. While `miso_oe` is 0, `miso` is 0.
- R9: If select is released before the eighth sample, the partial frame is dropped. `done_flag` stays 0 and `rd_data` keeps its value, and the next frame starts from bit 7.
- R10: After reset, `done_flag`, `wcol_flag` and `miso_oe` are 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase: 0 = sample on leading edge, 1 = sample on trailing edge |
| wr_en | input | 1 | One-cycle strobe that writes the transmit byte |
| wr_data | input | 8 | Transmit byte for the next frame |
| rd_data | output | 8 | Last complete received byte |
| done_flag | output | 1 | Sticky frame-complete flag |
| done_clr | input | 1 | Clear pulse for `done_flag` |
| wcol_flag | output | 1 | Sticky write-collision flag |
| wcol_clr | input | 1 | Clear pulse for `wcol_flag` |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The bound assertions check the following on every cycle:
- a busy-time write sets the collision flag and leaves the transmit register unchanged;
- the collision flag only rises from such a write;
- the done flag only rises from a completed frame and falls after a clear;
- the received byte changes only at completion;
- the output enable stays off, and `miso` stays 0, while select is high.

Only the bench scenarios can show the following:
- the bit order and sampling edges in all four clock modes;
- the data returned to the master;
- back-to-back bytes under a continuous select;
- the discarding of a frame cut short by releasing select.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int unsigned FRAME_BITS = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic lead;
    logic trail;
    logic sel_fall;
  } spi_evt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slave_shift.sv
module spi_slave_shift #(
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          ss_n_s,
  input  logic [FW-1:0] tx_buf,
  output logic          active,
  output logic          busy,
  output logic          miso_bit,
  output logic          byte_done,
  output logic [FW-1:0] rx_byte
);
  import spi_slave_pkg::*;
  localparam int unsigned CW = $clog2(FW);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  logic          sck_q, ss_n_q, started;
  logic [CW-1:0] cnt;
  logic [FW-1:0] tx_sr, rx_sr;
  spi_evt_t      ev;
  logic          sample, launch;

  always_comb begin
    ev.lead     = ((sck_s ^ cpol) == 1'b1) && ((sck_q ^ cpol) == 1'b0);
    ev.trail    = ((sck_s ^ cpol) == 1'b0) && ((sck_q ^ cpol) == 1'b1);
    ev.sel_fall = !ss_n_s && ss_n_q;
  end

  assign active    = !ss_n_s;
  assign sample    = active && (cpha ? ev.trail : ev.lead);
  assign launch    = active && (cpha ? ev.lead : ev.trail);
  assign byte_done = sample && (cnt == LAST);
  assign busy      = active && (!cpha || started);
  assign miso_bit  = tx_sr[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      ss_n_q  <= 1'b1;
      started <= 1'b0;
      cnt     <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
    end else begin
      sck_q  <= sck_s;
      ss_n_q <= ss_n_s;
      if (!active) begin
        cnt     <= '0;
        started <= 1'b0;
      end else begin
        if (ev.sel_fall) tx_sr <= tx_buf;
        else if (launch) begin
          if (cpha && !started) tx_sr <= tx_buf;
          else tx_sr <= {tx_sr[FW-2:0], 1'b0};
        end
        if (ev.lead) started <= 1'b1;
        if (sample) begin
          rx_sr <= {rx_sr[FW-2:0], mosi_s};
          if (cnt == LAST) begin
            cnt     <= '0;
            started <= 1'b0;
            rx_byte <= {rx_sr[FW-2:0], mosi_s};
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int unsigned FW = spi_slave_pkg::FRAME_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_data,
  output logic [FW-1:0] rd_data,
  output logic          done_flag,
  input  logic          done_clr,
  output logic          wcol_flag,
  input  logic          wcol_clr,
  input  logic          sck,
  input  logic          mosi,
  input  logic          ss_n,
  output logic          miso,
  output logic          miso_oe
);
  import spi_slave_pkg::*;

  logic          sck_s, mosi_s, ss_n_s;
  logic          active, busy, miso_bit, byte_done;
  logic [FW-1:0] tx_buf;

  spi_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d({sck, mosi}), .q({sck_s, mosi_s})
  );

  spi_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d(ss_n), .q(ss_n_s)
  );

  spi_slave_shift #(.FW(FW)) u_core (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
    .sck_s(sck_s), .mosi_s(mosi_s), .ss_n_s(ss_n_s), .tx_buf(tx_buf),
    .active(active), .busy(busy), .miso_bit(miso_bit),
    .byte_done(byte_done), .rx_byte(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf    <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
    end else begin
      if (wr_en && !busy) tx_buf <= wr_data;
      if (byte_done) done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
      if (wr_en && busy) wcol_flag <= 1'b1;
      else if (wcol_clr) wcol_flag <= 1'b0;
    end
  end

  assign miso_oe = active;
  assign miso    = active ? miso_bit : 1'b0;
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk #(
  parameter int unsigned FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          busy,
  input logic          byte_done,
  input logic [FW-1:0] tx_buf,
  input logic [FW-1:0] rd_data,
  input logic          done_flag,
  input logic          done_clr,
  input logic          wcol_flag,
  input logic          ss_n,
  input logic          miso,
  input logic          miso_oe
);
  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol_flag);

  // R6
  wcol_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> $stable(tx_buf));

  // R6
  wcol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol_flag) |-> $past(wr_en && busy));

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(byte_done));

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !byte_done) |=> !done_flag);

  // R2
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(rd_data));

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2)) |-> (!miso_oe && !miso));
endmodule

bind spi_slave_port spi_slave_port_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
  .byte_done(byte_done), .tx_buf(tx_buf), .rd_data(rd_data),
  .done_flag(done_flag), .done_clr(done_clr), .wcol_flag(wcol_flag),
  .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe)
);

// File: tb/sim_spi_slave_port.sv
module sim_spi_slave_port;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       done_flag, wcol_flag, miso, miso_oe;
  logic       done_clr = 1'b0, wcol_clr = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit finished = 1'b0;

  spi_slave_port u0 (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .done_flag(done_flag), .done_clr(done_clr),
    .wcol_flag(wcol_flag), .wcol_clr(wcol_clr),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Master side of one byte; expected received byte goes to the scoreboard
  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi, input int nbits);
    exp_q.push_back(mo);
    mi = '0;
    if (!cpha) begin
      mosi = mo[7];
      wait_clk(H);
      for (int i = 7; i > 7 - nbits; i--) begin
        mi[i] = miso;
        sck = ~cpol;
        wait_clk(H);
        sck = cpol;
        if (i > 0) mosi = mo[i-1];
        wait_clk(H);
      end
    end else begin
      for (int i = 7; i > 7 - nbits; i--) begin
        sck = ~cpol;
        mosi = mo[i];
        wait_clk(H);
        mi[i] = miso;
        sck = cpol;
        wait_clk(H);
      end
    end
  endtask

  task automatic frame(input logic [7:0] mo, input logic [7:0] slave_tx, input string req);
    logic [7:0] mi;
    ss_n = 1'b0;
    wait_clk(H);
    chk(miso_oe == 1'b1, "R8", miso_oe, 1);
    if (!cpha) chk(miso == slave_tx[7], "R3", miso, slave_tx[7]);
    spi_byte(mo, mi, 8);
    wait_clk(H);
    ss_n = 1'b1;
    chk(mi == slave_tx, req, mi, slave_tx);
    wait_clk(2 * H);
    chk(miso_oe == 1'b0 && miso == 1'b0, "R8", {miso_oe, miso}, 0);
  endtask

  // Monitor: pop expected byte on each completed frame
  initial begin
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (done_flag && rst_n) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", rd_data, 0);
        end else begin
          e = exp_q.pop_front();
          chk(rd_data == e, "R2", rd_data, e);
        end
        wait_clk(3);
        chk(done_flag == 1'b1, "R5", done_flag, 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk(done_flag == 1'b0, "R5", done_flag, 0);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    logic [7:0] pat [4] = '{8'h5A, 8'hC3, 8'h96, 8'h0F};
    logic [7:0] mpat [4] = '{8'hA1, 8'h3E, 8'h7C, 8'hF0};
    wait_clk(3);
    // R10 reset state
    chk(done_flag == 0 && wcol_flag == 0 && miso_oe == 0, "R10", {done_flag, wcol_flag, miso_oe}, 0);
    chk(rd_data == 8'h00, "R10", rd_data, 0);
    rst_n = 1'b1;
    wait_clk(3);

    // R1 all four clock modes
    for (int m = 0; m < 4; m++) begin
      cpol = m[1];
      cpha = m[0];
      sck = cpol;
      wait_clk(4);
      host_write(pat[m]);
      frame(mpat[m], pat[m], "R1");
      wait_clk(8);
    end

    // R6 collision with cpha=0: write while selected is dropped
    cpol = 1'b0; cpha = 1'b0; sck = 1'b0;
    host_write(8'hA5);
    ss_n = 1'b0;
    wait_clk(4);
    host_write(8'h3C);
    chk(wcol_flag == 1'b1, "R6", wcol_flag, 1);
    spi_byte(8'h11, mi, 8);
    wait_clk(H);
    ss_n = 1'b1;
    chk(mi == 8'hA5, "R6", mi, 8'hA5);
    wait_clk(10);
    chk(wcol_flag == 1'b1, "R6", wcol_flag, 1);
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
    chk(wcol_flag == 1'b0, "R6", wcol_flag, 0);

    // R9 abort mid-byte
    ss_n = 1'b0;
    wait_clk(H);
    spi_byte(8'hEE, mi, 4);
    void'(exp_q.pop_back());
    ss_n = 1'b1;
    wait_clk(20);
    chk(done_flag == 1'b0, "R9", done_flag, 0);
    chk(rd_data == 8'h11, "R9", rd_data, 8'h11);
    frame(8'h42, 8'hA5, "R9");
    wait_clk(10);

    // R4 / R7 two bytes under one select with cpha=1, write between bytes
    cpol = 1'b1; cpha = 1'b1; sck = 1'b1;
    wait_clk(4);
    host_write(8'h81);
    ss_n = 1'b0;
    wait_clk(H);
    spi_byte(8'h24, mi, 8);
    chk(mi == 8'h81, "R4", mi, 8'h81);
    wait_clk(H);
    host_write(8'h7E);
    chk(wcol_flag == 1'b0, "R7", wcol_flag, 0);
    wait_clk(H);
    spi_byte(8'hB7, mi, 8);
    chk(mi == 8'h7E, "R7", mi, 8'h7E);
    wait_clk(H);
    ss_n = 1'b1;
    wait_clk(20);
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
    chk(rd_data == 8'hB7, "R2", rd_data, 8'hB7);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule